// File: doc/BRIEF.md
# System Counter-Timer with Processor Mode Control

This block is a free-running counter that climbs toward a programmable limit. Each step of the counter is one unit of a 22-bit field that sits at bits 30:9 of a 32-bit word, so one step is worth 512 in the register view, and the low nine bits always read as zero. The count advances once for every cycle in which the `tick_en` input is high. The system provides that strobe once per 500 ns. When the next count would reach or pass the limit, the count returns to zero, a sticky reached flag is set and a level interrupt goes high.

Software reaches the block through a word-addressed register bus that has single-cycle accesses and combinational read data. Offset 0 holds the limit. Writing it restarts the count, and reading it acknowledges the interrupt. Offset 1 returns the count with the reached flag in its top bit. Offset 2 changes the limit without disturbing the count. Offset 4 holds one user-mode bit per processor. Every processor whose bit changes on a write to offset 4 gets a one-cycle restart strobe, so that its own timer can reload.

Top module: `sys_cntr_timer`

## Requirements
- R1: After reset the limit is 0x7FFFFE00, the count and the reached flag are zero, `irq_o` is low, and `user_mode_o` and `restart_o` are zero.
- R2: A write to offset 0 stores bits 30:9 of the data as the limit and ignores bits 31 and 8:0. The same write clears the count and drops `irq_o`, but it leaves the reached flag as it was.
- R3: If a write to offset 0 or offset 2 carries a zero in bits 30:9, the stored limit becomes 0x7FFFFE00.
- R4: Each cycle with `tick_en` high adds one to the count field. If the incremented value is greater than or equal to the limit field, the count goes to zero, and the reached flag and `irq_o` are both 1 from the next cycle on.
- R5: A read of offset 1 returns the reached flag in bit 31, the count in bits 30:9 and zeros in bits 8:0. This read changes no state.
- R6: A read of offset 0 returns the limit in bits 30:9, with bit 31 and bits 8:0 at zero. After the read, both the reached flag and `irq_o` are cleared.
- R7: A write to offset 2 stores the limit in the same way as offset 0, but it leaves the count, the reached flag and `irq_o` unchanged.
- R8: If the limit is reached in the same cycle as a read of offset 0, the reached flag and `irq_o` end up set.
- R9: If a write to offset 0 falls in a cycle with `tick_en` high, the write takes priority. The count becomes zero, no limit event occurs and `irq_o` ends low.
- R10: A write to offset 4 stores data bits NUM_CPU-1:0 as the mode bits. These drive `user_mode_o`, and a read of offset 4 returns them zero-extended.
- R11: In the cycle after a write to offset 4, `restart_o` equals the old mode bits XOR the new ones, and it is zero in every other cycle.
- R12: A read of offset 3, 5, 6 or 7 returns zero. A write to any of these offsets changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One count step per high cycle (500 ns time base) |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | 1 | Level interrupt |
| user_mode_o | output | NUM_CPU | Stored per-processor user-mode bits |
| restart_o | output | NUM_CPU | One-cycle restart strobes per processor |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a limit hit and a read of offset 0: the read acknowledges the interrupt while the tick sets it again. The second pair is a limit hit and a write to offset 0, where the write restarts the count. The bench provokes each pair by first stepping the count to one below the limit and then issuing the bus access with `tick_en` held high in that same cycle. The first case passes when `irq_o` is high and the count reads back as zero with bit 31 set. The second passes when `irq_o` is low and the count reads back as zero with the reached flag unchanged.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int DATA_W    = 32;
  localparam int FIELD_LSB = 9;
  localparam int FIELD_MSB = 30;
  localparam int FIELD_W   = FIELD_MSB - FIELD_LSB + 1;

  localparam logic [2:0] OFS_LIM_RST  = 3'd0;
  localparam logic [2:0] OFS_COUNT    = 3'd1;
  localparam logic [2:0] OFS_LIM_KEEP = 3'd2;
  localparam logic [2:0] OFS_MODE     = 3'd4;

  // Extract a limit from write data; zero means the largest limit.
  function automatic logic [FIELD_W-1:0] sct_limit_of(input logic [DATA_W-1:0] wd);
    logic [FIELD_W-1:0] f;
    f = wd[FIELD_MSB:FIELD_LSB];
    return (f == '0) ? {FIELD_W{1'b1}} : f;
  endfunction

  // Place a field into a bus word with a chosen top bit.
  function automatic logic [DATA_W-1:0] sct_word_of(input logic top, input logic [FIELD_W-1:0] f);
    return {top, f, {FIELD_LSB{1'b0}}};
  endfunction

  // True when one more step reaches or passes the limit.
  function automatic logic sct_at_limit(input logic [FIELD_W-1:0] cnt, input logic [FIELD_W-1:0] lim);
    logic [FIELD_W:0] nxt;
    nxt = {1'b0, cnt} + 1'b1;
    return nxt >= {1'b0, lim};
  endfunction
endpackage

// File: rtl/sct_counter.sv
module sct_counter
  import sct_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               wr_lim_rst,
  input  logic               wr_lim_keep,
  input  logic               rd_lim,
  input  logic [FIELD_W-1:0] new_limit,
  output logic [FIELD_W-1:0] count_o,
  output logic [FIELD_W-1:0] limit_o,
  output logic               reached_o,
  output logic               irq_o,
  output logic               hit_o
);
  logic [FIELD_W-1:0] count_q, limit_q;
  logic               reached_q, irq_q;
  logic               at_lim;

  assign at_lim = sct_at_limit(count_q, limit_q);
  assign hit_o  = tick_en && !wr_lim_rst && at_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= '0;
      limit_q   <= {FIELD_W{1'b1}};
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (wr_lim_rst) begin
        limit_q <= new_limit;
        count_q <= '0;
      end else begin
        if (wr_lim_keep) limit_q <= new_limit;
        if (tick_en)     count_q <= at_lim ? '0 : count_q + 1'b1;
      end
      if (hit_o)       reached_q <= 1'b1;
      else if (rd_lim) reached_q <= 1'b0;
      if (hit_o)                       irq_q <= 1'b1;
      else if (rd_lim || wr_lim_rst)   irq_q <= 1'b0;
    end
  end

  assign count_o   = count_q;
  assign limit_o   = limit_q;
  assign reached_o = reached_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/sct_mode_reg.sv
module sct_mode_reg #(
  parameter int NUM_CPU = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_mode,
  input  logic [NUM_CPU-1:0] new_mode,
  output logic [NUM_CPU-1:0] mode_o,
  output logic [NUM_CPU-1:0] restart_o
);
  logic [NUM_CPU-1:0] mode_q, restart_q;

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode_q[g]    <= 1'b0;
        restart_q[g] <= 1'b0;
      end else begin
        restart_q[g] <= wr_mode && (new_mode[g] != mode_q[g]);
        if (wr_mode) mode_q[g] <= new_mode[g];
      end
    end
  end

  assign mode_o    = mode_q;
  assign restart_o = restart_q;
endmodule

// File: rtl/sct_rdmux.sv
module sct_rdmux
  import sct_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 3
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [FIELD_W-1:0] limit,
  input  logic [FIELD_W-1:0] count,
  input  logic               reached,
  input  logic [NUM_CPU-1:0] mode,
  output logic [DATA_W-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    case (3'(addr))
      OFS_LIM_RST: rdata = sct_word_of(1'b0, limit);
      OFS_COUNT:   rdata = sct_word_of(reached, count);
      OFS_MODE:    rdata = DATA_W'(mode);
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/sys_cntr_timer.sv
module sys_cntr_timer
  import sct_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o,
  output logic [NUM_CPU-1:0] user_mode_o,
  output logic [NUM_CPU-1:0] restart_o
);
  // Named events for the checker
  logic ev_wr_lim_rst, ev_wr_lim_keep, ev_rd_lim, ev_wr_mode, ev_wr_undef, ev_hit;
  logic [FIELD_W-1:0] cnt_field, lim_field;
  logic               reached;

  assign ev_wr_lim_rst  = bus_sel && bus_wr  && (3'(bus_addr) == OFS_LIM_RST);
  assign ev_wr_lim_keep = bus_sel && bus_wr  && (3'(bus_addr) == OFS_LIM_KEEP);
  assign ev_rd_lim      = bus_sel && !bus_wr && (3'(bus_addr) == OFS_LIM_RST);
  assign ev_wr_mode     = bus_sel && bus_wr  && (3'(bus_addr) == OFS_MODE);
  assign ev_wr_undef    = bus_sel && bus_wr  && !ev_wr_lim_rst && !ev_wr_lim_keep
                          && !ev_wr_mode && (3'(bus_addr) != OFS_COUNT);

  sct_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .wr_lim_rst (ev_wr_lim_rst),
    .wr_lim_keep(ev_wr_lim_keep),
    .rd_lim     (ev_rd_lim),
    .new_limit  (sct_limit_of(bus_wdata)),
    .count_o    (cnt_field),
    .limit_o    (lim_field),
    .reached_o  (reached),
    .irq_o      (irq_o),
    .hit_o      (ev_hit)
  );

  sct_mode_reg #(.NUM_CPU(NUM_CPU)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_mode  (ev_wr_mode),
    .new_mode (bus_wdata[NUM_CPU-1:0]),
    .mode_o   (user_mode_o),
    .restart_o(restart_o)
  );

  sct_rdmux #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_rd (
    .addr   (bus_addr),
    .limit  (lim_field),
    .count  (cnt_field),
    .reached(reached),
    .mode   (user_mode_o),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/sct_checker.sv
module sct_checker
  import sct_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_en,
  input logic               hit,
  input logic               wr_lim_rst,
  input logic               wr_lim_keep,
  input logic               rd_lim,
  input logic               wr_mode,
  input logic               wr_undef,
  input logic [FIELD_W-1:0] cnt,
  input logic [FIELD_W-1:0] lim,
  input logic               reached,
  input logic               irq,
  input logic [NUM_CPU-1:0] mode,
  input logic [NUM_CPU-1:0] restart
);
  // R4: an asserted interrupt always has the sticky flag behind it
  p_irq_has_reached_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> reached);

  // R4 / R8: a limit hit leaves flag and interrupt set with count zero
  p_hit_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (reached && irq && cnt == '0));

  // R6: acknowledgement clears both when no hit competes
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lim && !hit) |=> (!reached && !irq));

  // R2 / R9: limit write with restart zeroes count and interrupt
  p_write_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lim_rst |=> (cnt == '0 && !irq));

  // R7: limit write without restart keeps the count when idle
  p_keep_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lim_keep && !tick_en) |=> $stable(cnt));

  // R11: strobes equal the changed mode bits
  p_restart_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (restart == ($past(mode) ^ mode)));

  // R11: strobes appear only after a mode write
  p_restart_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (restart != '0) |-> $past(wr_mode));

  // R12: writes to undefined offsets touch nothing
  p_undef_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_undef && !tick_en && !rd_lim) |=> ($stable(cnt) && $stable(lim) && $stable(mode) && $stable(reached)));
endmodule

bind sys_cntr_timer sct_checker #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .hit        (ev_hit),
  .wr_lim_rst (ev_wr_lim_rst),
  .wr_lim_keep(ev_wr_lim_keep),
  .rd_lim     (ev_rd_lim),
  .wr_mode    (ev_wr_mode),
  .wr_undef   (ev_wr_undef),
  .cnt        (cnt_field),
  .lim        (lim_field),
  .reached    (reached),
  .irq        (irq_o),
  .mode       (user_mode_o),
  .restart    (restart_o)
);

// File: tb/sys_cntr_timer_tb.sv
module sys_cntr_timer_tb;
  localparam int NUM_CPU = 4;
  localparam int ADDR_W  = 3;
  localparam logic [31:0] MAXLIM = 32'h7FFF_FE00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic bus_sel = 1'b0;
  logic bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o;
  logic [NUM_CPU-1:0] user_mode_o, restart_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sys_cntr_timer #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .user_mode_o(user_mode_o), .restart_o(restart_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle; inputs change at negedge, result sampled at next negedge.
  task automatic access(input bit wr, input int ofs, input logic [31:0] wd,
                        input bit tick, output logic [31:0] rd);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = ADDR_W'(ofs); bus_wdata = wd; tick_en = tick;
    #1 rd = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic wr(input int ofs, input logic [31:0] wd);
    logic [31:0] d;
    access(1'b1, ofs, wd, 1'b0, d);
  endtask

  task automatic rd(input int ofs, output logic [31:0] d);
    access(1'b0, ofs, 32'h0, 1'b0, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
    end
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", {31'h0, irq_o}, 32'h0);
    check("R1 mode", 32'(user_mode_o), 32'h0);
    check("R1 restart", 32'(restart_o), 32'h0);
    rd(1, d); check("R1 count", d, 32'h0);
    rd(0, d); check("R1 limit", d, MAXLIM);
  endtask

  task automatic t_count_and_reach;
    logic [31:0] d;
    wr(0, 32'h8000_0BFF);                 // field 5, stray bits ignored
    rd(0, d); check("R2 limit mask", d, 32'h0000_0A00);
    ticks(3);
    rd(1, d); check("R4 count 3", d, 32'h0000_0600);
    check("R4 no irq yet", {31'h0, irq_o}, 32'h0);
    ticks(2);
    check("R4 irq on reach", {31'h0, irq_o}, 32'h1);
    rd(1, d); check("R5 reached in bit31", d, 32'h8000_0000);
    rd(1, d); check("R5 read no side effect", d, 32'h8000_0000);
    check("R5 irq kept", {31'h0, irq_o}, 32'h1);
    rd(0, d); check("R6 limit readback", d, 32'h0000_0A00);
    check("R6 irq cleared", {31'h0, irq_o}, 32'h0);
    rd(1, d); check("R6 reached cleared", d, 32'h0);
  endtask

  task automatic t_zero_limit;
    logic [31:0] d;
    wr(0, 32'h0000_01FF);
    rd(0, d); check("R3 zero at offset 0", d, MAXLIM);
    wr(2, 32'h8000_0000);
    rd(0, d); check("R3 zero at offset 2", d, MAXLIM);
  endtask

  task automatic t_write_keeps_reached;
    logic [31:0] d;
    wr(0, 32'h0000_0400);                 // limit 2
    ticks(2);
    check("R4 reach at 2", {31'h0, irq_o}, 32'h1);
    ticks(1);
    wr(0, 32'h0000_0400);
    check("R2 write drops irq", {31'h0, irq_o}, 32'h0);
    rd(1, d); check("R2 count zero reached kept", d, 32'h8000_0000);
    rd(0, d);                              // acknowledge
  endtask

  task automatic t_keep_limit;
    logic [31:0] d;
    wr(0, 32'h0000_1000);                 // limit 8
    ticks(3);
    wr(2, 32'h0000_0C00);                 // limit 6, count stays 3
    rd(1, d); check("R7 count untouched", d, 32'h0000_0600);
    rd(0, d); check("R7 new limit", d, 32'h0000_0C00);
    ticks(2);
    check("R7 no irq at 5", {31'h0, irq_o}, 32'h0);
    ticks(1);
    check("R7 irq at new limit", {31'h0, irq_o}, 32'h1);
    rd(0, d);
  endtask

  task automatic t_read_vs_hit;
    logic [31:0] d;
    wr(0, 32'h0000_0800);                 // limit 4
    ticks(3);
    access(1'b0, 0, 32'h0, 1'b1, d);      // acknowledge and reach together
    check("R8 read data", d, 32'h0000_0800);
    check("R8 irq wins", {31'h0, irq_o}, 32'h1);
    rd(1, d); check("R8 reached wins", d, 32'h8000_0000);
    rd(0, d);
  endtask

  task automatic t_write_vs_hit;
    logic [31:0] d;
    ticks(3);                             // count 3, limit 4
    access(1'b1, 0, 32'h0000_0800, 1'b1, d);
    check("R9 irq low", {31'h0, irq_o}, 32'h0);
    rd(1, d); check("R9 count zero no reach", d, 32'h0);
  endtask

  task automatic t_mode;
    logic [31:0] d;
    wr(4, 32'hFFFF_FFF5);
    check("R11 restart first", 32'(restart_o), 32'h5);
    check("R10 mode out", 32'(user_mode_o), 32'h5);
    @(negedge clk);
    check("R11 one cycle", 32'(restart_o), 32'h0);
    rd(4, d); check("R10 mode read", d, 32'h5);
    wr(4, 32'h6);
    check("R11 changed bits", 32'(restart_o), 32'h3);
    wr(4, 32'h6);
    check("R11 no change no strobe", 32'(restart_o), 32'h0);
  endtask

  task automatic t_undef;
    logic [31:0] d;
    ticks(2);                             // count 2, limit 4
    for (int o = 3; o < 8; o++) begin
      if (o != 4) begin
        wr(o, 32'hFFFF_FFFF);
        rd(o, d); check("R12 read zero", d, 32'h0);
      end
    end
    check("R12 no strobe", 32'(restart_o), 32'h0);
    rd(1, d); check("R12 count kept", d, 32'h0000_0400);
    rd(4, d); check("R12 mode kept", d, 32'h6);
    rd(0, d); check("R12 limit kept", d, 32'h0000_0800);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_and_reach();
    t_zero_limit();
    t_write_keeps_reached();
    t_keep_limit();
    t_read_vs_hit();
    t_write_vs_hit();
    t_mode();
    t_undef();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule